// File: doc/BRIEF.md
# Smart-Card T=0 Character Error Controller

This block handles character-level error signalling on a half-duplex smart-card line in the byte-oriented T=0 protocol. When a character arrives, it checks even parity over the eight data bits plus the parity bit. On a mismatch it raises a parity-error flag and decides whether to request a NACK, which is a low level on the shared I/O line. When the block transmits, it watches the line for the card's NACK after each character and asks for the character to be sent again. A programmable limit bounds the number of retries.

Bit shifting and baud generation live outside the block. The surrounding logic supplies the following inputs:
- a strobe that marks the end of each received or transmitted character;
- a pulse every half bit time (`half_tick_i`);
- the sampled line level.

One limit, a 3-bit iteration code, bounds two things. It caps the number of back-to-back parity errors that get a NACK when that cap is switched on. It also caps how many times a refused character is retransmitted. An inhibit input stops every NACK and overrides the cap. A 3-bit guard code sets the spacing between transmitted characters.

Top module: `sc_t0_errctl`

## Requirements
- R1: A received character counts as a parity error when the nine bits {data[7:0], parity} hold an odd number of ones. `perr_o` shows the result of the latest character from the cycle after `rx_done_i`. It is 1 for an error and 0 for a good character.
- R2: With `inhibit_nack_i` = 1, `nack_drive_o` stays 0 after any received character.
- R3: `inhibit_nack_i` = 1 suppresses NACKs even when `limit_nacks_i` = 1.
- R4: With both `inhibit_nack_i` = 0 and `limit_nacks_i` = 0, every received parity error produces a NACK.
- R5: With `limit_nacks_i` = 1 and `inhibit_nack_i` = 0, a run of consecutive parity errors is limited to L NACKs, one for each of the first L errors. Later errors in the same run get none. L is the iteration limit.
- R6: A character received with correct parity restarts the consecutive-error run.
- R7: The iteration limit L equals `max_iter_i` for codes 1 to 7. Code 0 is treated as 1.
- R8: A NACK begins at the first `half_tick_i` after `rx_done_i`, which is half a bit after the parity bit ends. `nack_drive_o` stays high until the third tick, so the NACK lasts one bit time.
- R9: `perr_o` is set on a parity error whether or not a NACK is requested.
- R10: After `tx_done_i`, the block samples the line at the 2nd half tick. A low level means the card refused the character.
- R11: `retx_req_o` pulses for one cycle on the 2·(G+2)-th half tick after `tx_done_i`, where G is `guard_code_i`. This spaces characters 2 to 9 bit times apart. The pulse only occurs for a refused character.
- R12: A character can be retransmitted at most L times. When a retransmitted character is refused again with L retries already used, `retry_exh_o` rises instead of `retx_req_o` and the retry count restarts. The next `tx_done_i` clears `retry_exh_o`.
- R13: A character the card accepts produces no retransmit request and restarts the retry count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_data_i | input | 8 | Received data bits |
| rx_par_i | input | 1 | Received parity bit |
| rx_done_i | input | 1 | One-cycle strobe at the end of a received parity bit |
| tx_done_i | input | 1 | One-cycle strobe at the end of a transmitted parity bit |
| line_i | input | 1 | Sampled I/O line level |
| half_tick_i | input | 1 | Pulse every half bit time |
| inhibit_nack_i | input | 1 | Never request a NACK |
| limit_nacks_i | input | 1 | Cap consecutive NACKs at the iteration limit |
| max_iter_i | input | 3 | Iteration limit code (0 is treated as 1) |
| guard_code_i | input | 3 | Guard code, 2 + code bit times |
| nack_drive_o | output | 1 | Request to pull the line low |
| perr_o | output | 1 | Parity result of the latest received character |
| retx_req_o | output | 1 | One-cycle request to send the character again |
| retry_exh_o | output | 1 | Retry limit exceeded for the current character |

## Verification
The hardest states to reach are the two ends of a counted run. The first is the error that exceeds the NACK cap. The second is a refusal that arrives with every retry already used. Both depend on several consecutive characters under the same configuration, so single random characters seldom get there.

Directed runs cover these boundaries for small limits, including reserved code 0. The card's refusal is pulled low only during the second half tick, which also pins the sampling instant. Random runs then mix error rates, limits and guard codes, and a bench model tracks both run counts.

// File: rtl/sc_t0_pkg.sv
package sc_t0_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ITER_W = 3;
  localparam int unsigned GT_W   = 3;

  typedef enum logic [1:0] {RX_IDLE, RX_WAIT, RX_DRIVE} rx_st_e;
  typedef enum logic [0:0] {TX_IDLE, TX_WIN} tx_st_e;
endpackage

// File: rtl/sc_t0_parity.sv
module sc_t0_parity #(
  parameter int unsigned DW = sc_t0_pkg::DATA_W
) (
  input  logic [DW-1:0] data_i,
  input  logic          par_i,
  output logic          odd_o
);
  assign odd_o = ^{data_i, par_i};
endmodule

// File: rtl/sc_t0_rx_nack.sv
module sc_t0_rx_nack
  import sc_t0_pkg::*;
#(
  parameter int unsigned IW = ITER_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_done_i,
  input  logic          perr_now_i,
  input  logic          inhibit_i,
  input  logic          cap_en_i,
  input  logic [IW-1:0] limit_i,
  input  logic          half_tick_i,
  output logic          nack_o,
  output logic          perr_o
);
  localparam logic [IW-1:0] CNT_MAX = '1;

  rx_st_e        st_q, st_d;
  logic [IW-1:0] run_q, run_d;
  logic          perr_q, perr_d;
  logic          hc_q, hc_d;
  logic          send;

  assign send = perr_now_i && !inhibit_i && (!cap_en_i || (run_q < limit_i));

  always_comb begin
    st_d   = st_q;
    run_d  = run_q;
    perr_d = perr_q;
    hc_d   = hc_q;
    case (st_q)
      RX_WAIT: if (half_tick_i) begin
        st_d = RX_DRIVE;
        hc_d = 1'b0;
      end
      RX_DRIVE: if (half_tick_i) begin
        if (hc_q) st_d = RX_IDLE;
        else      hc_d = 1'b1;
      end
      default: ;
    endcase
    if (rx_done_i) begin
      perr_d = perr_now_i;
      if (perr_now_i) run_d = (run_q == CNT_MAX) ? run_q : run_q + 1'b1;
      else            run_d = '0;
      st_d = send ? RX_WAIT : RX_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      run_q  <= '0;
      perr_q <= 1'b0;
      hc_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      run_q  <= run_d;
      perr_q <= perr_d;
      hc_q   <= hc_d;
    end
  end

  assign nack_o = (st_q == RX_DRIVE);
  assign perr_o = perr_q;

  a_r2_inhibit_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && inhibit_i) |=> (st_q == RX_IDLE));
  a_r5_cap_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && perr_now_i && cap_en_i && (run_q >= limit_i)) |=> !nack_o);
  a_r8_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nack_o) |-> $past(half_tick_i));
  a_r8_fall_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nack_o) |-> ($past(half_tick_i) || $past(rx_done_i)));
  a_r9_perr_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_i |=> (perr_o == $past(perr_now_i)));
endmodule

// File: rtl/sc_t0_tx_retry.sv
module sc_t0_tx_retry
  import sc_t0_pkg::*;
#(
  parameter int unsigned IW = ITER_W,
  parameter int unsigned GW = GT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_done_i,
  input  logic          line_i,
  input  logic          half_tick_i,
  input  logic [IW-1:0] limit_i,
  input  logic [GW-1:0] guard_i,
  output logic          retx_o,
  output logic          exh_o
);
  localparam int unsigned HALF_MAX = 2 * ((1 << GW) + 1);
  localparam int unsigned HC_W     = $clog2(HALF_MAX + 1);
  localparam logic [HC_W-1:0] SAMPLE_AT = HC_W'(2);

  tx_st_e          st_q, st_d;
  logic [HC_W-1:0] hc_q, hc_d, hc_n, guard_half;
  logic [IW-1:0]   rc_q, rc_d;
  logic            nk_q, nk_d, nk_eff;
  logic            exh_q, exh_d, retx_q, retx_d;

  assign guard_half = ({{(HC_W-GW){1'b0}}, guard_i} + HC_W'(2)) << 1;
  assign hc_n       = hc_q + 1'b1;
  assign nk_eff     = (hc_n == SAMPLE_AT) ? !line_i : nk_q;

  always_comb begin
    st_d   = st_q;
    hc_d   = hc_q;
    rc_d   = rc_q;
    nk_d   = nk_q;
    exh_d  = exh_q;
    retx_d = 1'b0;
    if (st_q == TX_WIN && half_tick_i) begin
      hc_d = hc_n;
      nk_d = nk_eff;
      if (hc_n == guard_half) begin
        st_d = TX_IDLE;
        if (nk_eff) begin
          if (rc_q < limit_i) begin
            retx_d = 1'b1;
            rc_d   = rc_q + 1'b1;
          end else begin
            exh_d = 1'b1;
            rc_d  = '0;
          end
        end else begin
          rc_d = '0;
        end
      end
    end
    if (tx_done_i) begin
      st_d  = TX_WIN;
      hc_d  = '0;
      nk_d  = 1'b0;
      exh_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TX_IDLE;
      hc_q   <= '0;
      rc_q   <= '0;
      nk_q   <= 1'b0;
      exh_q  <= 1'b0;
      retx_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      hc_q   <= hc_d;
      rc_q   <= rc_d;
      nk_q   <= nk_d;
      exh_q  <= exh_d;
      retx_q <= retx_d;
    end
  end

  assign retx_o = retx_q;
  assign exh_o  = exh_q;

  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retx_o |=> !retx_o);
  a_r11_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(retx_o) |-> $past(half_tick_i));
  a_r12_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retx_o |-> !exh_o);
  a_r12_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retx_o |-> (rc_q <= limit_i));
  a_r12_clear_on_new: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i |=> !exh_o);
endmodule

// File: rtl/sc_t0_errctl.sv
module sc_t0_errctl
  import sc_t0_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_par_i,
  input  logic              rx_done_i,
  input  logic              tx_done_i,
  input  logic              line_i,
  input  logic              half_tick_i,
  input  logic              inhibit_nack_i,
  input  logic              limit_nacks_i,
  input  logic [ITER_W-1:0] max_iter_i,
  input  logic [GT_W-1:0]   guard_code_i,
  output logic              nack_drive_o,
  output logic              perr_o,
  output logic              retx_req_o,
  output logic              retry_exh_o
);
  logic [1:0]        rs_q;
  logic              rst_n;
  logic              odd;
  logic [ITER_W-1:0] limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  assign limit = (max_iter_i == '0) ? ITER_W'(1) : max_iter_i;

  sc_t0_parity #(.DW(DATA_W)) u_par (
    .data_i (rx_data_i),
    .par_i  (rx_par_i),
    .odd_o  (odd)
  );

  sc_t0_rx_nack #(.IW(ITER_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .rx_done_i   (rx_done_i),
    .perr_now_i  (odd),
    .inhibit_i   (inhibit_nack_i),
    .cap_en_i    (limit_nacks_i),
    .limit_i     (limit),
    .half_tick_i (half_tick_i),
    .nack_o      (nack_drive_o),
    .perr_o      (perr_o)
  );

  sc_t0_tx_retry #(.IW(ITER_W), .GW(GT_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .tx_done_i   (tx_done_i),
    .line_i      (line_i),
    .half_tick_i (half_tick_i),
    .limit_i     (limit),
    .guard_i     (guard_code_i),
    .retx_o      (retx_req_o),
    .exh_o       (retry_exh_o)
  );

  a_r7_limit_nonzero: assert property (@(posedge clk_i) disable iff (!rst_n)
    (limit != '0));
endmodule

// File: tb/tb_sc_t0_errctl.sv
`timescale 1ns/1ps
module tb_sc_t0_errctl;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [7:0] rx_data_i;
  logic       rx_par_i, rx_done_i, tx_done_i, line_i, half_tick_i;
  logic       inhibit_nack_i, limit_nacks_i;
  logic [2:0] max_iter_i, guard_code_i;
  logic       nack_drive_o, perr_o, retx_req_o, retry_exh_o;

  int total = 0;
  int bad   = 0;
  int m_run = 0;
  int m_rc  = 0;

  always #4 clk_i = ~clk_i;

  sc_t0_errctl dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int lim_of(input int mi);
    return (mi == 0) ? 1 : mi;
  endfunction

  task automatic tick();
    @(negedge clk_i) half_tick_i = 1'b1;
    @(negedge clk_i) half_tick_i = 1'b0;
  endtask

  task automatic rx_char(input logic [7:0] d, input bit err, input bit inh,
                         input bit cap, input int mi);
    int exp_n;
    @(negedge clk_i);
    inhibit_nack_i = inh;
    limit_nacks_i  = cap;
    max_iter_i     = 3'(mi);
    rx_data_i      = d;
    rx_par_i       = (^d) ^ err;
    rx_done_i      = 1'b1;
    exp_n = (err && !inh && (!cap || m_run < lim_of(mi))) ? 1 : 0;
    if (err) m_run = (m_run < 7) ? m_run + 1 : 7;
    else     m_run = 0;
    @(negedge clk_i) rx_done_i = 1'b0;
    chk("R1 R9 parity flag", int'(perr_o), int'(err));
    chk("R8 nack idle before first tick", int'(nack_drive_o), 0);
    tick();
    chk("R2 R3 R4 R5 R6 R7 nack after tick1", int'(nack_drive_o), exp_n);
    tick();
    chk("R8 nack held after tick2", int'(nack_drive_o), exp_n);
    tick();
    chk("R8 nack released after tick3", int'(nack_drive_o), 0);
  endtask

  task automatic tx_char(input bit card_nack, input int mi, input int g);
    int gh;
    int exp_retx;
    int exp_exh;
    @(negedge clk_i);
    max_iter_i   = 3'(mi);
    guard_code_i = 3'(g);
    tx_done_i    = 1'b1;
    @(negedge clk_i) tx_done_i = 1'b0;
    chk("R12 exhausted cleared by new char", int'(retry_exh_o), 0);
    gh = 2 * (g + 2);
    exp_retx = 0;
    exp_exh  = 0;
    if (card_nack) begin
      if (m_rc < lim_of(mi)) begin exp_retx = 1; m_rc++; end
      else begin exp_exh = 1; m_rc = 0; end
    end else begin
      m_rc = 0;
    end
    for (int k = 1; k <= gh; k++) begin
      line_i = (k == 2 && card_nack) ? 1'b0 : 1'b1;
      tick();
      line_i = 1'b1;
      if (k == gh - 1) chk("R11 no early retransmit", int'(retx_req_o), 0);
    end
    chk("R10 R11 R13 retransmit at guard end", int'(retx_req_o), exp_retx);
    chk("R12 exhausted flag", int'(retry_exh_o), exp_exh);
    @(negedge clk_i);
    chk("R11 retransmit one cycle", int'(retx_req_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F3C));
    rst_ni = 1'b0;
    rx_data_i = '0; rx_par_i = 1'b0; rx_done_i = 1'b0; tx_done_i = 1'b0;
    line_i = 1'b1; half_tick_i = 1'b0;
    inhibit_nack_i = 1'b0; limit_nacks_i = 1'b0;
    max_iter_i = 3'd1; guard_code_i = 3'd0;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("reset nack", int'(nack_drive_o), 0);
    chk("reset perr", int'(perr_o), 0);
    chk("reset retx", int'(retx_req_o), 0);
    chk("reset exhausted", int'(retry_exh_o), 0);

    // R1: good characters of various patterns
    rx_char(8'h00, 0, 0, 0, 1);
    rx_char(8'hA5, 0, 0, 0, 1);
    rx_char(8'h01, 0, 0, 0, 1);
    // R4: every error NACKed without the cap
    for (int i = 0; i < 5; i++) rx_char(8'h3C + 8'(i), 1, 0, 0, 1);
    rx_char(8'h11, 0, 0, 0, 1);
    // R2 R3 R9: inhibit wins over the cap, flag still set
    rx_char(8'h7E, 1, 1, 0, 3);
    rx_char(8'h7F, 1, 1, 1, 3);
    rx_char(8'h12, 0, 0, 0, 3);
    // R5 R6: limit 3 under the cap
    for (int i = 0; i < 5; i++) rx_char(8'h55, 1, 0, 1, 3);
    rx_char(8'h55, 0, 0, 1, 3);
    rx_char(8'h55, 1, 0, 1, 3);
    rx_char(8'h00, 0, 0, 1, 3);
    // R7: reserved code 0 behaves as 1
    for (int i = 0; i < 3; i++) rx_char(8'hC3, 1, 0, 1, 0);
    rx_char(8'h00, 0, 0, 1, 0);
    // R10 R11 R12 R13: limit 2, shortest guard
    tx_char(1, 2, 0);
    tx_char(1, 2, 0);
    tx_char(1, 2, 0);
    tx_char(0, 2, 0);
    tx_char(1, 2, 7);
    tx_char(0, 2, 7);
    tx_char(1, 2, 3);
    // R7 on transmit: code 0 allows one retry
    tx_char(0, 0, 1);
    tx_char(1, 0, 1);
    tx_char(1, 0, 1);

    for (int i = 0; i < 250; i++) begin
      rx_char(8'($urandom), ($urandom % 3) == 0, ($urandom % 6) == 0,
              $urandom % 2, int'($urandom % 8));
    end
    m_rc = 0;
    tx_char(0, 1, 0);
    for (int i = 0; i < 80; i++) begin
      tx_char(($urandom % 3) != 0, int'($urandom % 4), int'($urandom % 8));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule